// File: doc/BRIEF.md
# Paged Address Translation Unit

This block widens a 16-bit CPU address into a larger physical address. The upper nibble of the logical address picks one slot in a sixteen-slot page table. The content of that slot becomes the upper part of the physical address. The lower twelve bits are the offset within a 4 KB page and are not changed.

The CPU programs the block through an 8-bit write port that has two separate chip selects. One chip select loads page-table slots. The other loads a control register, which holds a single enable flag. While the flag is clear, the block is an identity map that zero-extends the logical address. Once the flag is set, every page is relocated through its slot. Each slot is twelve bits wide, but only its low eight bits can be written, so the reachable physical space is 1 MB.

Top module: `page_xlate_unit`

## Requirements
- R1: While the enable flag is 0, `phys_addr` equals `log_addr` zero-extended to 24 bits.
- R2: `phys_addr[11:0]` always equals `log_addr[11:0]`.
- R3: While the enable flag is 1, `phys_addr[23:12]` equals the slot selected by `log_addr[15:12]`.
- R4: When `cpu_we` and `tbl_cs` are both 1 at a rising clock edge, `cpu_wdata` is stored into the slot selected by `cpu_reg_sel[3:0]`. The new value is used from that edge onward.
- R5: When `cpu_we` and `ctl_cs` are both 1 at a rising clock edge, the enable flag takes `cpu_wdata[0]`. Bits 7:1 of the written byte are ignored, and the flag holds its value at every other edge.
- R6: `ctl_rdata` shows the enable flag in bit 0 and reads 0 in bits 7:1.
- R7: While `rst_n` is low, the enable flag is 0 and every slot is 0.
- R8: `phys_addr[23:20]` is always 0, because only the low 8 bits of a slot are writable.
- R9: At an edge where `cpu_we` is 0, or where neither chip select is 1, neither the table nor the flag changes.
- R10: When both chip selects are active together with `cpu_we`, the slot write and the flag write both take effect at the same edge.
- R11: Translation is combinational. A change on `log_addr` reaches `phys_addr` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the table and control writes |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_reg_sel | input | 4 | Low CPU address bits; select the slot to write |
| cpu_wdata | input | 8 | CPU write data |
| tbl_cs | input | 1 | Chip select for the page-table window |
| ctl_cs | input | 1 | Chip select for the control register |
| ctl_rdata | output | 8 | Control register value (enable flag in bit 0) |
| log_addr | input | 16 | Logical address to translate |
| phys_addr | output | 24 | Translated physical address |

## Verification
A slot write and a control write can happen at the same clock edge, because the two chip selects are decoded independently and share one data byte. The bench raises both selects together, with a byte whose bit 0 turns translation on, while the flag is still clear. It then applies a logical address in the page just written. The next translation must show the new slot value in the upper bits, which proves that both writes landed. A second case writes a slot while translation is already live and checks that the old value is still seen before the edge and the new value after it.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
   // Bit of the control byte that carries the enable flag
   localparam int unsigned CTL_EN_BIT = 0;

   // Number of slot bits that actually get stored
   function automatic int unsigned stored_width(input int unsigned entry_w,
                                                input int unsigned wr_w);
      return (wr_w < entry_w) ? wr_w : entry_w;
   endfunction
endpackage

// File: rtl/ptab_regs.sv
module ptab_regs #(
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned STORE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [STORE_W-1:0] wr_data,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [STORE_W-1:0] rd_entry
);
   localparam int unsigned NUM_SLOTS = 2 ** IDX_W;

   logic [STORE_W-1:0] slot_q [NUM_SLOTS];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[s] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(s)))
            slot_q[s] <= wr_data;
      end
   end

   assign rd_entry = slot_q[rd_idx];
endmodule

// File: rtl/ctl_reg.sv
module ctl_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_bit,
   output logic              en_q,
   output logic [DATA_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (wr_en)
         en_q <= wr_bit;
   end

   always_comb begin
      rdata = '0;
      rdata[page_xlate_pkg::CTL_EN_BIT] = en_q;
   end
endmodule

// File: rtl/xlate_path.sv
module xlate_path #(
   parameter int unsigned LOG_AW  = 16,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned ENTRY_W = 12,
   parameter int unsigned STORE_W = 8
) (
   input  logic                            en,
   input  logic [LOG_AW-1:0]               log_addr,
   input  logic [STORE_W-1:0]              entry,
   output logic [LOG_AW-IDX_W+ENTRY_W-1:0] phys_addr
);
   localparam int unsigned OFF_W   = LOG_AW - IDX_W;
   localparam int unsigned PHYS_AW = OFF_W + ENTRY_W;

   logic [ENTRY_W-1:0] frame;

   if (STORE_W == ENTRY_W) begin : g_full
      assign frame = entry;
   end else begin : g_pad
      assign frame = {{(ENTRY_W-STORE_W){1'b0}}, entry};
   end

   always_comb begin
      if (en)
         phys_addr = {frame, log_addr[OFF_W-1:0]};
      else
         phys_addr = PHYS_AW'(log_addr);
   end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
   parameter int unsigned LOG_AW     = 16,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned ENTRY_W    = 12,
   parameter int unsigned WR_ENTRY_W = 8,
   parameter int unsigned DATA_W     = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cpu_we,
   input  logic [IDX_W-1:0]                cpu_reg_sel,
   input  logic [DATA_W-1:0]               cpu_wdata,
   input  logic                            tbl_cs,
   input  logic                            ctl_cs,
   output logic [DATA_W-1:0]               ctl_rdata,
   input  logic [LOG_AW-1:0]               log_addr,
   output logic [LOG_AW-IDX_W+ENTRY_W-1:0] phys_addr
);
   localparam int unsigned STORE_W = page_xlate_pkg::stored_width(ENTRY_W, WR_ENTRY_W);

   if (IDX_W >= LOG_AW) begin : g_bad_idx
      $error("IDX_W must be narrower than LOG_AW");
   end
   if (WR_ENTRY_W > DATA_W) begin : g_bad_wr
      $error("WR_ENTRY_W must fit in the data bus");
   end
   if (ENTRY_W < IDX_W) begin : g_bad_entry
      $error("ENTRY_W must be at least IDX_W");
   end

   logic               en;
   logic [STORE_W-1:0] cur_entry;

   ptab_regs #(.IDX_W(IDX_W), .STORE_W(STORE_W)) table_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cpu_we && tbl_cs),
      .wr_idx   (cpu_reg_sel),
      .wr_data  (cpu_wdata[STORE_W-1:0]),
      .rd_idx   (log_addr[LOG_AW-1 -: IDX_W]),
      .rd_entry (cur_entry)
   );

   ctl_reg #(.DATA_W(DATA_W)) ctl_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cpu_we && ctl_cs),
      .wr_bit (cpu_wdata[page_xlate_pkg::CTL_EN_BIT]),
      .en_q   (en),
      .rdata  (ctl_rdata)
   );

   xlate_path #(.LOG_AW(LOG_AW), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .STORE_W(STORE_W)) path_i (
      .en        (en),
      .log_addr  (log_addr),
      .entry     (cur_entry),
      .phys_addr (phys_addr)
   );
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
   parameter int unsigned LOG_AW     = 16,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned ENTRY_W    = 12,
   parameter int unsigned WR_ENTRY_W = 8,
   parameter int unsigned DATA_W     = 8
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            cpu_we,
   input logic [IDX_W-1:0]                cpu_reg_sel,
   input logic [DATA_W-1:0]               cpu_wdata,
   input logic                            tbl_cs,
   input logic                            ctl_cs,
   input logic [DATA_W-1:0]               ctl_rdata,
   input logic [LOG_AW-1:0]               log_addr,
   input logic [LOG_AW-IDX_W+ENTRY_W-1:0] phys_addr
);
   localparam int unsigned OFF_W   = LOG_AW - IDX_W;
   localparam int unsigned PHYS_AW = OFF_W + ENTRY_W;
   localparam int unsigned TOP_W   = PHYS_AW - (OFF_W + WR_ENTRY_W);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R1
   identity_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[0] |-> phys_addr == PHYS_AW'(log_addr));

   // R2
   offset_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[OFF_W-1:0] == log_addr[OFF_W-1:0]);

   // R8
   high_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[PHYS_AW-1 -: TOP_W] == '0);

   // R6
   ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[DATA_W-1:1] == '0);

   // R5
   ctl_load_chk: assert property (@(posedge clk) disable iff (!(rst_n && armed))
      (cpu_we && ctl_cs) |=> ctl_rdata[0] == $past(cpu_wdata[0]));

   // R9
   ctl_hold_chk: assert property (@(posedge clk) disable iff (!(rst_n && armed))
      !(cpu_we && ctl_cs) |=> $stable(ctl_rdata[0]));
endmodule

bind page_xlate_unit page_xlate_chk #(
   .LOG_AW(LOG_AW), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W),
   .WR_ENTRY_W(WR_ENTRY_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/page_xlate_unit_tb_top.sv
module page_xlate_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_we = 1'b0;
   logic [3:0]  cpu_reg_sel = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        tbl_cs = 1'b0;
   logic        ctl_cs = 1'b0;
   logic [7:0]  ctl_rdata;
   logic [15:0] log_addr = '0;
   logic [23:0] phys_addr;

   always #4 clk = ~clk;

   page_xlate_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_reg_sel(cpu_reg_sel),
      .cpu_wdata(cpu_wdata), .tbl_cs(tbl_cs), .ctl_cs(ctl_cs),
      .ctl_rdata(ctl_rdata), .log_addr(log_addr), .phys_addr(phys_addr)
   );

   typedef struct {
      bit          is_ctl;
      logic [23:0] exp;
      string       tag;
   } item_t;

   item_t queue_q[$];
   event  sample_ev;
   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   logic [7:0] model_slot [16];
   bit         model_en = 1'b0;

   function automatic logic [23:0] model_phys(input logic [15:0] a);
      if (!model_en) return {8'h00, a};
      return {4'h0, model_slot[a[15:12]], a[11:0]};
   endfunction

   task automatic apply(input logic [15:0] a, input string tag);
      item_t it;
      @(negedge clk);
      log_addr = a;
      it.is_ctl = 1'b0; it.exp = model_phys(a); it.tag = tag;
      queue_q.push_back(it);
      -> sample_ev;
   endtask

   task automatic check_ctl(input string tag);
      item_t it;
      @(negedge clk);
      it.is_ctl = 1'b1; it.exp = {16'h0, 7'h0, model_en}; it.tag = tag;
      queue_q.push_back(it);
      -> sample_ev;
   endtask

   task automatic cpu_write(input bit we, input bit tcs, input bit ccs,
                            input logic [3:0] sel, input logic [7:0] d);
      @(negedge clk);
      cpu_we = we; tbl_cs = tcs; ctl_cs = ccs; cpu_reg_sel = sel; cpu_wdata = d;
      @(posedge clk);
      #1;
      cpu_we = 1'b0; tbl_cs = 1'b0; ctl_cs = 1'b0;
      if (we && tcs) model_slot[sel] = d;
      if (we && ccs) model_en = d[0];
   endtask

   // Monitor: pops one expected item per stimulus and compares
   initial begin
      forever begin
         @(sample_ev);
         #2;
         while (queue_q.size() > 0) begin
            item_t it;
            logic [23:0] act;
            it = queue_q.pop_front();
            act = it.is_ctl ? {16'h0, ctl_rdata} : phys_addr;
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) model_slot[i] = 8'h00;
      repeat (3) @(posedge clk);
      // R7 R6: reset values
      check_ctl("R7 reset control");
      apply(16'hABCD, "R1 identity after reset");
      @(negedge clk); rst_n = 1'b1;
      apply(16'h0000, "R1 identity zero");
      apply(16'hFFFF, "R1 identity top");
      // R7: slots zero once enabled
      cpu_write(1'b1, 1'b0, 1'b1, 4'h0, 8'h01);
      check_ctl("R6 control reads enable");
      apply(16'h7ABC, "R7 slot zero after reset");
      // R4 R3 R2
      cpu_write(1'b1, 1'b1, 1'b0, 4'h5, 8'hC7);
      apply(16'h5123, "R3 relocated page");
      apply(16'h5FFF, "R2 offset passthrough");
      apply(16'h4123, "R4 neighbour slot untouched");
      // R8: all-ones slot keeps upper bits zero
      cpu_write(1'b1, 1'b1, 1'b0, 4'hF, 8'hFF);
      apply(16'hFFFF, "R8 upper nibble zero");
      // R11: change address without a clock edge between stimulus and sample
      apply(16'h5001, "R11 combinational A");
      @(negedge clk); #1;
      log_addr = 16'hF002;
      begin
         item_t it;
         it.is_ctl = 1'b0; it.exp = model_phys(16'hF002); it.tag = "R11 combinational B";
         queue_q.push_back(it);
         -> sample_ev;
      end
      // R9: write strobe without select, select without strobe
      cpu_write(1'b1, 1'b0, 1'b0, 4'h5, 8'h11);
      cpu_write(1'b0, 1'b1, 1'b1, 4'h5, 8'h10);
      apply(16'h5123, "R9 table unchanged");
      check_ctl("R9 enable unchanged");
      // R5: byte with bit0 clear and others set disables
      cpu_write(1'b1, 1'b0, 1'b1, 4'h0, 8'hFE);
      check_ctl("R5 disable with upper bits set");
      apply(16'h5123, "R5 identity again");
      // R10: both selects together
      cpu_write(1'b1, 1'b1, 1'b1, 4'h3, 8'h43);
      check_ctl("R10 enable via joint write");
      apply(16'h3ABC, "R10 slot via joint write");
      // R4: rewrite live slot
      apply(16'h3001, "R4 before rewrite");
      cpu_write(1'b1, 1'b1, 1'b0, 4'h3, 8'h9A);
      apply(16'h3001, "R4 after rewrite");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule